// File: doc/BRIEF.md
# Masked Register-Poll Wait Engine

This block carries out the wait step of a boot-time configuration loader. The loader decodes a wait block from serial memory and hands over three fields: a double-word register address, a 32-bit expected value and a 32-bit mask. The engine then holds the loader and keeps reading the internal register bus until one of three things happens. The masked compare matches. The bus reports the address as unmapped. The programmed cycle budget runs out.

A match or an unmapped address lets loading carry on. An unmapped address also sets a sticky status flag. When the budget runs out, the engine tells the loader to abort and raises two sticky flags: a timeout flag and a reset-halt flag. Software clears any of the flags by writing a one to its bit of the clear input.

Top module: `wait_poll_engine`

## Requirements
- R1: `start_ready` is high only while the engine is idle. A cycle with `start_valid` and `start_ready` both high accepts the block and latches its address, value, mask and the timeout limit. Every read request carries the latched address on `rd_addr`.
- R2: A read counts as a match when `((rd_data ^ value) & ~mask) == 0`. A mask bit of 1 makes that data bit don't-care, and a mask of all ones matches any data.
- R3: At most one read is outstanding. `rd_req` is a single-cycle pulse. A response (`rd_ack` high) may come in the same cycle as its request or later. A response that neither matches nor is unmapped is followed by a new request in the next cycle.
- R4: On a matching response, `done_valid` pulses for one cycle, starting on the cycle after the response, with `done_abort` = 0. No further read is issued.
- R5: On a response with `rd_unmapped` high, the engine does no compare and issues no further reads. It sets `sts_unmapped` and finishes with `done_abort` = 0, on the same timing as R4.
- R6: A timer is cleared on acceptance and counts each busy cycle. The first busy cycle is count 0. In the busy cycle where the count equals the limit L with no deciding response, the engine times out. On the next cycle, `done_valid` and `done_abort` are both 1, and `sts_timeout` and `halt_req` are set.
- R7: A matching or unmapped response in the same cycle as the timeout wins, and the result is resume, not abort.
- R8: With L = 0, the first busy cycle already times out unless a matching or unmapped response arrives in that same cycle.
- R9: `sts_unmapped` (clear bit 0), `sts_timeout` (clear bit 1) and `halt_req` (clear bit 2) stay set across later waits until the matching bit of `flag_clr` is high for a cycle. A set in the same cycle takes priority over a clear.
- R10: Synchronous reset returns the engine to idle, with `start_ready` = 1, all flags low, and `rd_req` and `done_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Loader presents a decoded wait block |
| start_ready | output | 1 | Engine is idle and will accept a block |
| blk_addr | input | ADDR_W | Double-word register address to poll |
| blk_value | input | 32 | Expected register value |
| blk_mask | input | 32 | Don't-care mask, 1 = bit ignored |
| tmo_limit | input | TMR_W | Timeout limit in cycles, latched on acceptance |
| rd_req | output | 1 | Register read request pulse |
| rd_addr | output | ADDR_W | Register read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| rd_unmapped | input | 1 | Response reports an unmapped address |
| flag_clr | input | 3 | Write-one-to-clear for unmapped, timeout, halt |
| sts_unmapped | output | 1 | Sticky unmapped-access flag |
| sts_timeout | output | 1 | Sticky wait-timeout flag |
| halt_req | output | 1 | Sticky reset-halt flag |
| done_valid | output | 1 | One-cycle completion pulse to the loader |
| done_abort | output | 1 | With done_valid: 1 = abort loading, 0 = resume |

## Verification
The assertions check the protocol rules on every cycle:
- no read request outside a wait;
- no second request while a read is still unanswered;
- single-cycle completion pulses;
- every abort comes with both timeout flags, and the timeout flag rises only together with an abort.

Only the bench scenarios can show that the completion arrives in the right cycle, for each combination of read latency, number of non-matching reads, unmapped responses and limit. That includes the tie between a response and the timeout, and the zero limit. The scenarios also show that the mask really excludes bits and that flags stay set across waits until cleared.

// File: rtl/wait_pkg.sv
package wait_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } wstate_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_MATCH = 2'd1,
        OUT_UNMAP = 2'd2,
        OUT_TMO   = 2'd3
    } outcome_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [DATA_W-1:0] mask;
    } cmp_pair_t;

    localparam int FLAG_UNMAP = 0;
    localparam int FLAG_TMO   = 1;
    localparam int FLAG_HALT  = 2;
    localparam int NUM_FLAGS  = 3;

    function automatic logic masked_hit(input logic [DATA_W-1:0] rd, input cmp_pair_t p);
        return ((rd ^ p.value) & ~p.mask) == '0;
    endfunction

endpackage

// File: rtl/wait_cmp.sv
module wait_cmp
    import wait_pkg::*;
(
    input  cmp_pair_t         pair,
    input  logic [DATA_W-1:0] rdata,
    output logic              hit
);
    always_comb hit = masked_hit(rdata, pair);
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (en && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb expired = en && (cnt_q >= limit);
endmodule

// File: rtl/wait_flags.sv
module wait_flags
    import wait_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] set,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                f_q <= 1'b0;
            end else if (set[i]) begin
                f_q <= 1'b1;
            end else if (clr[i]) begin
                f_q <= 1'b0;
            end
        end
        assign flags[i] = f_q;
    end
endmodule

// File: rtl/wait_poll_engine.sv
module wait_poll_engine
    import wait_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic [31:0]       blk_value,
    input  logic [31:0]       blk_mask,
    input  logic [TMR_W-1:0]  tmo_limit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    input  logic              rd_unmapped,
    input  logic [2:0]        flag_clr,
    output logic              sts_unmapped,
    output logic              sts_timeout,
    output logic              halt_req,
    output logic              done_valid,
    output logic              done_abort
);
    wstate_e           state_q;
    logic              issued_q;
    logic [ADDR_W-1:0] addr_q;
    cmp_pair_t         pair_q;
    logic [TMR_W-1:0]  limit_q;
    logic              done_valid_q;
    logic              done_abort_q;

    logic     busy;
    logic     accept;
    logic     rsp;
    logic     hit;
    logic     expired;
    outcome_e outcome;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    assign busy        = (state_q == ST_POLL);
    assign start_ready = (state_q == ST_IDLE);
    assign accept      = start_valid && start_ready;
    assign rd_req      = busy && !issued_q;
    assign rd_addr     = addr_q;
    assign rsp         = busy && rd_ack;

    wait_cmp u_cmp (
        .pair  (pair_q),
        .rdata (rd_data),
        .hit   (hit)
    );

    wait_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .en      (busy),
        .limit   (limit_q),
        .expired (expired)
    );

    // A deciding response outranks a timeout in the same cycle.
    always_comb begin
        outcome = OUT_NONE;
        if (rsp && rd_unmapped) begin
            outcome = OUT_UNMAP;
        end else if (rsp && hit) begin
            outcome = OUT_MATCH;
        end else if (expired) begin
            outcome = OUT_TMO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            issued_q     <= 1'b0;
            addr_q       <= '0;
            pair_q       <= '0;
            limit_q      <= '0;
            done_valid_q <= 1'b0;
            done_abort_q <= 1'b0;
        end else begin
            done_valid_q <= 1'b0;
            done_abort_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q      <= ST_POLL;
                        issued_q     <= 1'b0;
                        addr_q       <= blk_addr;
                        pair_q.value <= blk_value;
                        pair_q.mask  <= blk_mask;
                        limit_q      <= tmo_limit;
                    end
                end
                ST_POLL: begin
                    if (outcome != OUT_NONE) begin
                        state_q      <= ST_IDLE;
                        issued_q     <= 1'b0;
                        done_valid_q <= 1'b1;
                        done_abort_q <= (outcome == OUT_TMO);
                    end else if (rsp) begin
                        issued_q <= 1'b0;
                    end else if (rd_req) begin
                        issued_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_UNMAP] = (outcome == OUT_UNMAP);
        flag_set[FLAG_TMO]   = (outcome == OUT_TMO);
        flag_set[FLAG_HALT]  = (outcome == OUT_TMO);
    end

    wait_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    assign sts_unmapped = flag_q[FLAG_UNMAP];
    assign sts_timeout  = flag_q[FLAG_TMO];
    assign halt_req     = flag_q[FLAG_HALT];
    assign done_valid   = done_valid_q;
    assign done_abort   = done_abort_q;
endmodule

// File: rtl/wait_poll_checker.sv
module wait_poll_checker (
    input logic clk,
    input logic rst,
    input logic start_valid,
    input logic start_ready,
    input logic rd_req,
    input logic rd_ack,
    input logic done_valid,
    input logic done_abort,
    input logic sts_timeout,
    input logic halt_req
);
    assert_req_only_busy_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !start_ready);

    assert_accept_leaves_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_ready) |=> !start_ready);

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> !rd_req);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    assert_abort_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        done_abort |-> done_valid);

    assert_abort_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_abort) |-> (sts_timeout && halt_req));

    assert_tmo_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_timeout) |-> (done_valid && done_abort));
endmodule

bind wait_poll_engine wait_poll_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .done_valid  (done_valid),
    .done_abort  (done_abort),
    .sts_timeout (sts_timeout),
    .halt_req    (halt_req)
);

// File: tb/sim_wait_poll_engine.sv
module sim_wait_poll_engine;
    localparam int ADDR_W = 30;
    localparam int TMR_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_valid = 1'b0;
    logic              start_ready;
    logic [ADDR_W-1:0] blk_addr = '0;
    logic [31:0]       blk_value = '0;
    logic [31:0]       blk_mask = '0;
    logic [TMR_W-1:0]  tmo_limit = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [31:0]       rd_data = '0;
    logic              rd_unmapped = 1'b0;
    logic [2:0]        flag_clr = '0;
    logic              sts_unmapped, sts_timeout, halt_req, done_valid, done_abort;

    int checks = 0;
    int errors = 0;
    bit exp_unm = 0;
    bit exp_tmo = 0;

    always #10 clk = ~clk;

    wait_poll_engine #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u0 (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .blk_addr(blk_addr), .blk_value(blk_value), .blk_mask(blk_mask),
        .tmo_limit(tmo_limit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_unmapped(rd_unmapped), .flag_clr(flag_clr),
        .sts_unmapped(sts_unmapped), .sts_timeout(sts_timeout), .halt_req(halt_req),
        .done_valid(done_valid), .done_abort(done_abort)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Busy cycle in which the wait ends (count from 0) and whether it aborts.
    function automatic int exp_end(input int lat, input int k, input bit unm,
                                   input int lim, output bit abort);
        int t;
        t = unm ? lat : (k - 1) * (lat + 1) + lat;
        abort = (t > lim);
        return abort ? lim : t;
    endfunction

    task automatic run_wait(input logic [ADDR_W-1:0] a, input logic [31:0] v,
                            input logic [31:0] m, input int lat, input int k,
                            input bit unm, input int lim, input bit do_clear,
                            input string tag);
        int  reqs = 0;
        int  rem = 0;
        bit  active = 0;
        bit  addr_ok = 1;
        int  got = -1;
        int  flip = -1;
        bit  e_abort;
        int  e_end;
        logic [31:0] good;
        e_end = exp_end(lat, k, unm, lim, e_abort);
        for (int b = 0; b < 32; b++) if (!m[b] && flip < 0) flip = b;
        @(negedge clk);
        chk(start_ready == 1'b1, "R1", {tag, " ready before start"}, start_ready, 1);
        start_valid = 1'b1; blk_addr = a; blk_value = v; blk_mask = m;
        tmo_limit = TMR_W'(lim);
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            start_valid = 1'b0; rd_ack = 1'b0; rd_unmapped = 1'b0;
            blk_addr = ~a; blk_value = ~v;
            if (done_valid) begin got = n; break; end
            if (rd_req) begin
                reqs++; active = 1; rem = lat;
                if (rd_addr != a) addr_ok = 0;
            end
            if (active) begin
                if (rem == 0) begin
                    good = v ^ ($urandom & m);
                    rd_ack = 1'b1;
                    rd_unmapped = unm;
                    rd_data = (reqs >= k || flip < 0) ? good : (good ^ (32'd1 << flip));
                    active = 0;
                end else begin
                    rem--;
                end
            end
        end
        if (e_abort) exp_tmo = 1;
        if (!e_abort && unm) exp_unm = 1;
        chk(addr_ok, "R1", {tag, " read address"}, addr_ok, 1);
        chk(got == e_end + 1, e_abort ? "R6" : (unm ? "R5" : "R4"),
            {tag, " completion cycle"}, got, e_end + 1);
        chk(done_abort == e_abort, e_abort ? "R6" : "R4", {tag, " abort flag"},
            done_abort, e_abort);
        if (!e_abort)
            chk(reqs == (unm ? 1 : k), unm ? "R5" : "R3", {tag, " read count"}, reqs, unm ? 1 : k);
        chk(sts_unmapped == exp_unm, "R9", {tag, " unmapped flag"}, sts_unmapped, exp_unm);
        chk(sts_timeout == exp_tmo && halt_req == exp_tmo, "R9", {tag, " timeout/halt flags"},
            {sts_timeout, halt_req}, {exp_tmo, exp_tmo});
        if (do_clear) begin
            @(negedge clk);
            flag_clr = 3'b111;
            @(negedge clk);
            flag_clr = 3'b000;
            exp_unm = 0; exp_tmo = 0;
            chk({sts_unmapped, sts_timeout, halt_req} == 3'b000, "R9", {tag, " cleared"},
                {sts_unmapped, sts_timeout, halt_req}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0417));
        repeat (3) @(negedge clk);
        chk(start_ready == 1'b1 && rd_req == 1'b0 && done_valid == 1'b0, "R10", "reset outputs",
            {start_ready, rd_req, done_valid}, 3'b100);
        chk({sts_unmapped, sts_timeout, halt_req} == 3'b000, "R10", "reset flags",
            {sts_unmapped, sts_timeout, halt_req}, 0);
        rst = 1'b0;

        run_wait(30'h123, 32'hCAFE_F00D, 32'h0000_00FF, 2, 1, 0, 100, 1, "R4 first-read match");
        run_wait(30'h0456, 32'h1234_5678, 32'h0F0F_0000, 1, 4, 0, 100, 1, "R3 fourth-read match");
        run_wait(30'h3ABC, 32'h0, 32'hFFFF_FFFF, 1, 1, 0, 50, 1, "R2 all-ones mask");
        run_wait(30'h0777, 32'hA5A5_A5A5, 32'h0, 3, 1, 1, 100, 0, "R5 unmapped");
        run_wait(30'h0778, 32'h0000_0001, 32'h0, 0, 2, 0, 100, 0, "R9 unmapped stays set");
        run_wait(30'h0999, 32'hDEAD_BEEF, 32'h0, 2, 50, 0, 20, 0, "R6 timeout");
        run_wait(30'h099A, 32'h0, 32'h0, 0, 1, 0, 100, 1, "R9 timeout stays set");
        run_wait(30'h0100, 32'h5555_0000, 32'h0000_FFFF, 2, 2, 0, 5, 1, "R7 tie resumes");
        run_wait(30'h0101, 32'h0, 32'h0, 2, 2, 0, 4, 1, "R6 one cycle short");
        run_wait(30'h0200, 32'h7, 32'h0, 0, 1, 0, 0, 1, "R8 zero limit instant match");
        run_wait(30'h0201, 32'h7, 32'h0, 1, 1, 0, 0, 1, "R8 zero limit late read");
        run_wait(30'h0202, 32'h7, 32'h0, 0, 2, 0, 0, 1, "R8 zero limit mismatch");
        run_wait(30'h0203, 32'h7, 32'h0, 0, 1, 1, 0, 1, "R8 zero limit unmapped");

        for (int i = 0; i < 40; i++) begin
            logic [31:0] mk;
            mk = $urandom & $urandom;
            run_wait(ADDR_W'($urandom), $urandom, mk, int'($urandom % 4),
                     1 + int'($urandom % 6), ($urandom % 8) == 0, int'($urandom % 31),
                     ($urandom % 2) == 0, "R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule